// File: doc/BRIEF.md
# Paired-Register I2C GPIO Expander

This block is an I2C target that owns sixteen general-purpose pins split into two 8-bit ports. Eight byte-wide registers sit behind the bus in four pairs. Indices 0/1 hold the input values of port 0/1 and are read-only. Indices 2/3 are the output latches, 4/5 are the polarity masks and 6/7 are the direction controls. A controller addresses the target and sends a command byte whose low three bits set a register pointer. Each following data byte goes to, or comes from, that pointer. After every byte the pointer flips only its lowest bit. A long transfer therefore keeps alternating between the two registers of one pair until STOP.

SCL and SDA arrive already synchronised to `clk`. The block pulls SDA low through `sda_oe`. A direction bit of 1 leaves the pin as an input (`pin_oe` low). A direction bit of 0 drives the matching output-latch bit onto the pin.

The link controller is a state machine with these states:
- `ST_IDLE`: waits for START.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: acknowledges the address.
- `ST_CMD`: shifts in the command byte.
- `ST_CMD_ACK`: acknowledges the command and loads the pointer.
- `ST_WR`: shifts in a data byte.
- `ST_WR_ACK`: acknowledges the byte and commits it.
- `ST_RD`: shifts out a data byte.
- `ST_RD_ACK`: samples the controller's acknowledge.

Transitions:
- START in any state moves to `ST_ADDR`, and STOP in any state moves to `ST_IDLE`.
- `ST_ADDR` moves to `ST_ADDR_ACK` after eight bits with a matching address, or to `ST_IDLE` on a mismatch.
- `ST_ADDR_ACK` moves to `ST_RD` when the R/W bit is 1, otherwise to `ST_CMD`.
- `ST_CMD` moves to `ST_CMD_ACK`, and `ST_CMD_ACK` moves to `ST_WR`.
- `ST_WR` and `ST_WR_ACK` alternate for as long as data bytes arrive.
- `ST_RD` moves to `ST_RD_ACK`.
- `ST_RD_ACK` moves back to `ST_RD` when the controller acknowledges, or to `ST_IDLE` on a not-acknowledge.

Top module: `gpio_pair_expander`

## Requirements
- R1: After reset, both output latches read 0xFF, both polarity masks read 0x00 and both direction registers read 0xFF, so `pin_oe` is 0x0000 and `pin_o` is 0xFFFF.
- R2: The target acknowledges only the 7-bit address {ADDR_PREFIX, addr_pins}. For any other address it acknowledges no byte and changes no register.
- R3: In a write, the target acknowledges the address, the command byte and every data byte. The command's low three bits select the first register.
- R4: Successive written data bytes alternate between the two registers of the selected pair, with no limit on their number. Bytes 0x12, 0x34, 0x56 sent with command 3 leave port 1's output latch at 0x56 and port 0's at 0x34.
- R5: Bytes written to indices 0 and 1 are acknowledged and have no effect on any register or pin.
- R6: A read is a write of the address and command, then a repeated START and the address with R/W = 1. Read data starts at the selected register and alternates within its pair.
- R7: Reading index 0 or 1 returns the pin value of that port XOR its polarity mask. The pins are sampled at the start of the acknowledge slot of the address byte or of the previous data byte.
- R8: Port bit k of `pin_oe` is the inverse of direction bit k. `pin_o` carries the output latches (port 0 in bits 7:0).
- R9: After the controller does not acknowledge a read byte, the target releases SDA until the next START or STOP.
- R10: A written byte reaches its register on the falling SCL edge that ends its acknowledge clock, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| addr_pins | input | 3 | Low three bits of the target address |
| pin_i | input | 16 | Pin levels, port 0 in bits 7:0 |
| pin_o | output | 16 | Output latch values toward the pads |
| pin_oe | output | 16 | Pin drive enables, 1 drives |

## Verification
The bench builds the block with the default prefix 4'b0100 and ties `addr_pins` to 3'b010, so the target answers at 0x22. With these values the bench can send a neighbouring address (pins 3'b011) and watch that the target stays silent and the registers are untouched. It drives the fixed pin pattern 0xA53C so that every byte read back, raw or polarity-flipped, has a value that can be predicted. It can also pause with SCL high inside an acknowledge clock to observe exactly when a write commits.

// File: rtl/xp_pkg.sv
package xp_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned PORTS   = 2;
    localparam int unsigned PIN_W   = BYTE_W * PORTS;
    localparam int unsigned IDX_W   = 3;
    localparam int unsigned CNT_W   = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK
    } link_state_t;
endpackage

// File: rtl/xp_bus_events.sv
module xp_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise = scl_i & ~scl_q;
    assign scl_fall = ~scl_i & scl_q;
    assign start_ev = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/xp_regfile.sv
module xp_regfile
    import xp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic [BYTE_W-1:0]        wr_data,
    input  logic                     cap_en,
    input  logic [PIN_W-1:0]         pin_i,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [BYTE_W-1:0]        rd_data,
    output logic [PIN_W-1:0]         pin_o,
    output logic [PIN_W-1:0]         pin_oe
);
    logic [PORTS-1:0][BYTE_W-1:0] out_q, pol_q, cfg_q, cap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '1;
            pol_q <= '0;
            cfg_q <= '1;
            cap_q <= '0;
        end else begin
            if (cap_en) begin
                cap_q <= pin_i;
            end
            if (wr_en) begin
                unique case (wr_idx[2:1])
                    2'd1:    out_q[wr_idx[0]] <= wr_data;
                    2'd2:    pol_q[wr_idx[0]] <= wr_data;
                    2'd3:    cfg_q[wr_idx[0]] <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (rd_idx[2:1])
            2'd0:    rd_data = cap_q[rd_idx[0]] ^ pol_q[rd_idx[0]];
            2'd1:    rd_data = out_q[rd_idx[0]];
            2'd2:    rd_data = pol_q[rd_idx[0]];
            default: rd_data = cfg_q[rd_idx[0]];
        endcase
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign pin_o[p*BYTE_W +: BYTE_W]  = out_q[p];
        assign pin_oe[p*BYTE_W +: BYTE_W] = ~cfg_q[p];
    end

    // R10
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));

    // R5
    input_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx[2:1] == 2'd0) |=>
        ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));
endmodule

// File: rtl/xp_link_fsm.sv
module xp_link_fsm
    import xp_pkg::*;
#(
    parameter logic [3:0] ADDR_PREFIX = 4'b0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_i,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_ev,
    input  logic               stop_ev,
    input  logic [2:0]         addr_pins,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               sda_oe,
    output logic               wr_en,
    output logic               cap_en,
    output logic [IDX_W-1:0]   ptr,
    output logic [BYTE_W-1:0]  wr_data
);
    link_state_t         state, nxt;
    logic [BYTE_W-1:0]   rx, tx;
    logic [CNT_W-1:0]    cnt;
    logic                addr_match, byte_end;

    assign addr_match = (rx[7:1] == {ADDR_PREFIX, addr_pins});
    assign byte_end   = scl_fall && (cnt == CNT_W'(BYTE_W));
    assign wr_data    = rx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (stop_ev) begin
            nxt = ST_IDLE;
        end else if (start_ev) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_ADDR:     if (byte_end) nxt = addr_match ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) nxt = rx[0] ? ST_RD : ST_CMD;
                ST_CMD:      if (byte_end) nxt = ST_CMD_ACK;
                ST_CMD_ACK:  if (scl_fall) nxt = ST_WR;
                ST_WR:       if (byte_end) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_WR;
                ST_RD:       if (byte_end) nxt = ST_RD_ACK;
                ST_RD_ACK: begin
                    if (scl_rise && sda_i) nxt = ST_IDLE;
                    else if (scl_fall)     nxt = ST_RD;
                end
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sda_oe = 1'b0;
        wr_en  = 1'b0;
        cap_en = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK: sda_oe = 1'b1;
            ST_WR_ACK: begin
                sda_oe = 1'b1;
                wr_en  = scl_fall && !start_ev && !stop_ev;
            end
            ST_ADDR: cap_en = byte_end && addr_match && !start_ev && !stop_ev;
            ST_RD: begin
                sda_oe = ~tx[BYTE_W-1];
                cap_en = byte_end && !start_ev && !stop_ev;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx  <= '0;
            tx  <= '1;
            cnt <= '0;
            ptr <= '0;
        end else if (start_ev || stop_ev) begin
            cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_CMD, ST_WR: begin
                    if (scl_rise && cnt < CNT_W'(BYTE_W)) begin
                        rx  <= {rx[BYTE_W-2:0], sda_i};
                        cnt <= cnt + 1'b1;
                    end
                    if (byte_end) cnt <= '0;
                end
                ST_RD: begin
                    if (scl_rise) cnt <= cnt + 1'b1;
                    if (byte_end)      cnt <= '0;
                    else if (scl_fall) tx  <= {tx[BYTE_W-2:0], 1'b1};
                end
                ST_ADDR_ACK: if (scl_fall && rx[0]) begin
                    tx  <= rd_data;
                    ptr <= {ptr[2:1], ~ptr[0]};
                end
                ST_CMD_ACK: if (scl_fall) ptr <= rx[IDX_W-1:0];
                ST_WR_ACK:  if (scl_fall) ptr <= {ptr[2:1], ~ptr[0]};
                ST_RD_ACK: if (scl_fall) begin
                    tx  <= rd_data;
                    ptr <= {ptr[2:1], ~ptr[0]};
                end
                default: ;
            endcase
        end
    end

    // R2
    bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && byte_end && !addr_match && !start_ev && !stop_ev)
        |=> (state == ST_IDLE));

    // R4
    ptr_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_ACK && scl_fall && !start_ev && !stop_ev)
        |=> (ptr == {$past(ptr[2:1]), ~$past(ptr[0])}));

    // R6
    read_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && scl_fall && rx[0] && !start_ev && !stop_ev)
        |=> (state == ST_RD));

    // R9
    nack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ACK && scl_rise && sda_i && !start_ev && !stop_ev)
        |=> !sda_oe);
endmodule

// File: rtl/gpio_pair_expander.sv
module gpio_pair_expander
    import xp_pkg::*;
#(
    parameter logic [3:0] ADDR_PREFIX = 4'b0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        addr_pins,
    input  logic [PIN_W-1:0]  pin_i,
    output logic [PIN_W-1:0]  pin_o,
    output logic [PIN_W-1:0]  pin_oe
);
    logic scl_rise, scl_fall, start_ev, stop_ev;
    logic wr_en, cap_en;
    logic [IDX_W-1:0]  ptr;
    logic [BYTE_W-1:0] wr_data, rd_data;

    xp_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    xp_link_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .addr_pins (addr_pins),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .cap_en    (cap_en),
        .ptr       (ptr),
        .wr_data   (wr_data)
    );

    xp_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (ptr),
        .wr_data (wr_data),
        .cap_en  (cap_en),
        .pin_i   (pin_i),
        .rd_idx  (ptr),
        .rd_data (rd_data),
        .pin_o   (pin_o),
        .pin_oe  (pin_oe)
    );
endmodule

// File: tb/gpio_pair_expander_tb.sv
module gpio_pair_expander_tb;
    localparam int Q = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        tb_low = 1'b0;
    logic        sda_oe;
    logic        sda_line;
    logic [15:0] pin_i = 16'hA53C;
    logic [15:0] pin_o, pin_oe;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    assign sda_line = ~(tb_low | sda_oe);

    always #5 clk = ~clk;

    gpio_pair_expander #(.ADDR_PREFIX(4'b0100)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .addr_pins (3'b010),
        .pin_i     (pin_i),
        .pin_o     (pin_o),
        .pin_oe    (pin_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        tb_low = 1'b0; tick(Q);
        scl = 1'b1;    tick(2*Q);
        tb_low = 1'b1; tick(2*Q);
        scl = 1'b0;    tick(Q);
    endtask

    task automatic bus_stop();
        tb_low = 1'b1; tick(Q);
        scl = 1'b1;    tick(2*Q);
        tb_low = 1'b0; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit hold, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            tb_low = ~b[i]; tick(Q);
            scl = 1'b1;     tick(2*Q);
            scl = 1'b0;     tick(Q);
        end
        tb_low = 1'b0; tick(Q);
        scl = 1'b1;    tick(Q);
        acked = ~sda_line;
        tick(Q);
        if (!hold) begin
            scl = 1'b0; tick(Q);
        end
    endtask

    task automatic ack_end();
        scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        tb_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl = 1'b0;
        end
        tick(Q);
        tb_low = give_ack; tick(Q);
        scl = 1'b1;        tick(2*Q);
        scl = 1'b0;        tick(Q);
        tb_low = 1'b0;
    endtask

    task automatic write_regs(input logic [7:0] cmd, input int n, input logic [7:0] d0,
                              input logic [7:0] d1, input logic [7:0] d2, input string req);
        bit a;
        logic [7:0] d [3];
        d[0] = d0; d[1] = d1; d[2] = d2;
        bus_start();
        send_byte(8'h44, 1'b0, a);
        check(a, "R3 address ack", 32'(a), 1);
        send_byte(cmd, 1'b0, a);
        check(a, "R3 command ack", 32'(a), 1);
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], 1'b0, a);
            check(a, req, 32'(a), 1);
        end
        bus_stop();
    endtask

    task automatic read_pair(input logic [7:0] cmd, input logic [7:0] e0,
                             input logic [7:0] e1, input string req);
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'h44, 1'b0, a);
        send_byte(cmd, 1'b0, a);
        bus_start();
        send_byte(8'h45, 1'b0, a);
        check(a, "R6 read address ack", 32'(a), 1);
        recv_byte(1'b1, b);
        check(b == e0, req, 32'(b), 32'(e0));
        recv_byte(1'b0, b);
        check(b == e1, req, 32'(b), 32'(e1));
        bus_stop();
    endtask

    task automatic t_reset();
        check(pin_oe == 16'h0000, "R1 reset pin_oe", 32'(pin_oe), 32'h0000);
        check(pin_o == 16'hFFFF, "R1 reset pin_o", 32'(pin_o), 32'hFFFF);
    endtask

    task automatic t_bad_addr();
        bit a;
        bus_start();
        send_byte(8'h46, 1'b0, a);
        check(!a, "R2 foreign address not acked", 32'(a), 0);
        send_byte(8'h02, 1'b0, a);
        check(!a, "R2 foreign command not acked", 32'(a), 0);
        send_byte(8'h00, 1'b0, a);
        check(!a, "R2 foreign data not acked", 32'(a), 0);
        bus_stop();
        check(pin_o == 16'hFFFF, "R2 outputs untouched", 32'(pin_o), 32'hFFFF);
    endtask

    task automatic t_write_alt();
        write_regs(8'h03, 3, 8'h12, 8'h34, 8'h56, "R3 data ack");
        check(pin_o == 16'h5634, "R4 alternating write", 32'(pin_o), 32'h5634);
    endtask

    task automatic t_commit_edge();
        bit a;
        bus_start();
        send_byte(8'h44, 1'b0, a);
        send_byte(8'hFE, 1'b0, a);
        send_byte(8'hF0, 1'b1, a);
        check(pin_oe == 16'h0000, "R10 not yet committed", 32'(pin_oe), 32'h0000);
        ack_end();
        check(pin_oe == 16'h000F, "R10 committed on ack fall", 32'(pin_oe), 32'h000F);
        bus_stop();
    endtask

    task automatic t_config();
        write_regs(8'h07, 1, 8'h00, 8'h00, 8'h00, "R8 data ack");
        check(pin_oe == 16'hFF0F, "R8 drive enables", 32'(pin_oe), 32'hFF0F);
        check(pin_o == 16'h5634, "R8 pin values", 32'(pin_o), 32'h5634);
    endtask

    task automatic t_input_ro();
        write_regs(8'h00, 2, 8'h77, 8'h88, 8'h00, "R5 input write acked");
        check(pin_o == 16'h5634, "R5 outputs unchanged", 32'(pin_o), 32'h5634);
        check(pin_oe == 16'hFF0F, "R5 enables unchanged", 32'(pin_oe), 32'hFF0F);
        read_pair(8'h00, 8'h3C, 8'hA5, "R5 input read");
    endtask

    task automatic t_polarity();
        bit a;
        logic [7:0] b;
        write_regs(8'h04, 2, 8'h0F, 8'hF0, 8'h00, "R7 mask ack");
        bus_start();
        send_byte(8'h44, 1'b0, a);
        send_byte(8'h01, 1'b0, a);
        bus_start();
        send_byte(8'h45, 1'b0, a);
        recv_byte(1'b1, b);
        check(b == 8'h55, "R7 port1 flipped", 32'(b), 32'h55);
        recv_byte(1'b1, b);
        check(b == 8'h33, "R7 port0 flipped", 32'(b), 32'h33);
        recv_byte(1'b0, b);
        check(b == 8'h55, "R6 third byte alternates", 32'(b), 32'h55);
        bus_stop();
    endtask

    task automatic t_read_regs();
        read_pair(8'h02, 8'h34, 8'h56, "R6 output pair read");
        read_pair(8'h07, 8'h00, 8'hF0, "R6 config pair read");
        read_pair(8'h0D, 8'hF0, 8'h0F, "R3 command low bits");
    endtask

    task automatic t_nack_release();
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(8'h44, 1'b0, a);
        send_byte(8'h03, 1'b0, a);
        bus_start();
        send_byte(8'h45, 1'b0, a);
        recv_byte(1'b0, b);
        check(b == 8'h56, "R9 last byte", 32'(b), 32'h56);
        recv_byte(1'b0, b);
        check(b == 8'hFF, "R9 SDA released after nack", 32'(b), 32'hFF);
        bus_stop();
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_bad_addr();
        t_write_alt();
        t_commit_edge();
        t_config();
        t_input_ro();
        t_polarity();
        t_read_regs();
        t_nack_release();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule